// File: doc/BRIEF.md
# Temperature Band Selector with Edge Hysteresis

This block turns a stream of signed temperature conversion results into a band index. The index addresses a per-band setting table, one entry per 2-degree band. The table itself lives elsewhere. The band boundaries are guarded by 1 degree of hysteresis, so a reading that wanders around an edge does not make the index chatter. When the index does move, a one-clock pulse tells the table logic to fetch new settings.

The latest applied reading is held as a two-byte result word. The result can be read through a small address port: the high byte sits at 60h and the low byte at 61h. A memory bus access must not see the result change under it. While the bus-busy flag is high, a finished conversion is parked and is not applied. It is applied on the first cycle in which the bus is idle again. A newer conversion that arrives while one is parked replaces it.

Top module: `temp_band_selector`

## Requirements
- R1: Temperatures are signed two's complement in 1/256-degree steps. A reading T maps to band floor((floor(T)+40)/2), clamped to 0..70, so band 0 holds -40 degrees and everything below it, and band 70 holds 100 degrees and everything above it.
- R2: The first conversion applied after reset loads the band of R1 directly, with no hysteresis.
- R3: Once a band is held, the index moves up only when the band of (T - 1 degree) is above the current index, and it then takes that value.
- R4: Once a band is held, the index moves down only when the band of (T + 1 degree) is below the current index, and it then takes that value.
- R5: A reading that satisfies neither R3 nor R4 leaves the index unchanged.
- R6: The result word holds the last applied reading. `rd_data` returns its bits 15:8 when `rd_addr` is 60h, its bits 7:0 when `rd_addr` is 61h, and 00h for any other address.
- R7: While `bus_busy` is high, neither the index nor the result word changes. A parked conversion is applied in the first cycle with `bus_busy` low. A later conversion that arrives while one is parked replaces the parked one.
- R8: `band_chg` is high for exactly one cycle after each applied conversion whose index differs from the previous index. The index before the first conversion counts as 0.
- R9: After reset, `band_idx` is 0, the result word is 0 and `band_chg` is 0.
- R10: Suppose a strobe is sampled at clock edge k with the bus idle. The index and the result change after edge k+1, not after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_valid | input | 1 | One-cycle strobe marking a finished conversion |
| conv_temp | input | 16 | Signed temperature, 1/256 degree per LSB |
| bus_busy | input | 1 | High while a memory read or write is in progress |
| rd_addr | input | 8 | Result read address |
| rd_data | output | 8 | Byte of the result word selected by `rd_addr` |
| band_idx | output | 7 | Selected table band |
| band_chg | output | 1 | One-cycle pulse when the band index changes |

## Verification
The bench builds the block with its default parameters: a -40 to +102 degree range, 2-degree bands and 1 degree of hysteresis. These give 71 bands and a 7-bit index. With that range, a half-degree sweep from -46 to +106 degrees in both directions covers every band edge, both clamp regions, and the up and down hysteresis windows. Zig-zag patterns around the edges, a busy window with a replaced parked value, and reloads straight after reset cover the remaining orderings.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  // Decision taken for one applied conversion
  typedef enum logic [1:0] {
    MOVE_HOLD = 2'd0,
    MOVE_UP   = 2'd1,
    MOVE_DOWN = 2'd2,
    MOVE_LOAD = 2'd3
  } move_e;

  // Number of bands spanning [tmin, tmax] in bdeg steps
  function automatic int band_count(input int tmin, input int tmax, input int bdeg);
    return (tmax - tmin) / bdeg;
  endfunction

  // Whole degrees (floor) of a fixed-point reading
  function automatic int whole_deg(input int t_q, input int frac_w);
    return t_q >>> frac_w;
  endfunction

  // Band of a fixed-point reading, clamped to 0..nb-1
  function automatic int band_of(input int t_q, input int frac_w, input int tmin,
                                 input int bdeg, input int nb);
    int rel;
    int q;
    rel = whole_deg(t_q, frac_w) - tmin;
    if (rel < 0) q = 0;
    else         q = rel / bdeg;
    if (q > nb - 1) q = nb - 1;
    return q;
  endfunction

  // Hysteresis offset in fixed-point units
  function automatic int hyst_q(input int hdeg, input int frac_w);
    return hdeg * (1 << frac_w);
  endfunction

endpackage

// File: rtl/tsel_capture.sv
module tsel_capture #(
  parameter int TEMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [TEMP_W-1:0] conv_temp,
  input  logic              bus_busy,
  output logic              apply,
  output logic [TEMP_W-1:0] apply_temp
);

  logic              pend_q;
  logic [TEMP_W-1:0] val_q;

  // A parked reading is released only on an idle bus cycle
  assign apply      = pend_q & ~bus_busy;
  assign apply_temp = val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      val_q  <= '0;
    end else begin
      if (conv_valid) begin
        pend_q <= 1'b1;
        val_q  <= conv_temp;
      end else if (apply) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R7: a parked reading survives a busy cycle untouched
  assert_park_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && bus_busy && !conv_valid) |=> (pend_q && $stable(val_q)));

  // R7: a released reading leaves the park slot empty unless refilled
  assert_park_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !conv_valid) |=> !pend_q);

endmodule

// File: rtl/tsel_band.sv
module tsel_band
  import tsel_pkg::*;
#(
  parameter int TEMP_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int T_MIN    = -40,
  parameter int BAND_DEG = 2,
  parameter int NBANDS   = 71,
  parameter int HYST_DEG = 1,
  parameter int IDX_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [TEMP_W-1:0] apply_temp,
  output logic [IDX_W-1:0]  idx,
  output logic              chg,
  output move_e             move
);

  localparam int HQ = hyst_q(HYST_DEG, FRAC_W);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NBANDS - 1);

  logic [IDX_W-1:0] idx_q;
  logic             seen_q;
  logic             chg_q;
  logic [IDX_W-1:0] nxt_idx;

  int t_s;
  int b_raw;
  int b_up;
  int b_dn;
  int cur;

  // Hysteresis decision, named so the checks can observe it
  always_comb begin
    t_s   = int'($signed(apply_temp));
    b_raw = band_of(t_s, FRAC_W, T_MIN, BAND_DEG, NBANDS);
    b_up  = band_of(t_s - HQ, FRAC_W, T_MIN, BAND_DEG, NBANDS);
    b_dn  = band_of(t_s + HQ, FRAC_W, T_MIN, BAND_DEG, NBANDS);
    cur   = int'(idx_q);
    if (!seen_q) begin
      move    = MOVE_LOAD;
      nxt_idx = IDX_W'(b_raw);
    end else if (b_up > cur) begin
      move    = MOVE_UP;
      nxt_idx = IDX_W'(b_up);
    end else if (b_dn < cur) begin
      move    = MOVE_DOWN;
      nxt_idx = IDX_W'(b_dn);
    end else begin
      move    = MOVE_HOLD;
      nxt_idx = idx_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      seen_q <= 1'b0;
      chg_q  <= 1'b0;
    end else if (apply) begin
      idx_q  <= nxt_idx;
      seen_q <= 1'b1;
      chg_q  <= (nxt_idx != idx_q);
    end else begin
      chg_q  <= 1'b0;
    end
  end

  assign idx = idx_q;
  assign chg = chg_q;

  // R1: index never leaves the band range
  assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_TOP);

  // R3: an upward decision raises the index
  assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && move == MOVE_UP) |=> (idx_q > $past(idx_q)));

  // R4: a downward decision lowers the index
  assert_step_dn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && move == MOVE_DOWN) |=> (idx_q < $past(idx_q)));

  // R5: without an applied reading the index is frozen
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(idx_q));

  // R2: the direct load happens only on the first applied reading
  assert_load_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (move == MOVE_LOAD) |-> !seen_q);

  // R8: the pulse follows an applied reading and marks every change
  assert_chg_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> $past(apply));
  assert_chg_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != $past(idx_q)) |-> chg_q);

endmodule

// File: rtl/tsel_result.sv
module tsel_result #(
  parameter int TEMP_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [TEMP_W-1:0] apply_temp,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [TEMP_W-1:0] res_word
);

  localparam int BYTE_W = 8;
  localparam int NBYTES = TEMP_W / BYTE_W;

  logic [TEMP_W-1:0] res_q;
  logic [BYTE_W-1:0] lane [NBYTES];

  always_ff @(posedge clk) begin
    if (!rst_n)     res_q <= '0;
    else if (apply) res_q <= apply_temp;
  end

  // Most significant byte sits at the lowest address
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    assign lane[k] = (rd_addr == ADDR_W'(BASE_ADDR + k))
                     ? res_q[TEMP_W-1-k*BYTE_W -: BYTE_W] : '0;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NBYTES; k++) rd_data = rd_data | lane[k];
  end

  assign res_word = res_q;

  // R6: the stored word only moves on an applied reading
  assert_res_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(res_q));

  // R6: an address outside the result window reads as zero
  assert_res_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr < ADDR_W'(BASE_ADDR) || rd_addr >= ADDR_W'(BASE_ADDR + NBYTES))
      |-> (rd_data == '0));

endmodule

// File: rtl/temp_band_selector.sv
module temp_band_selector
  import tsel_pkg::*;
#(
  parameter int TEMP_W    = 16,
  parameter int FRAC_W    = 8,
  parameter int T_MIN     = -40,
  parameter int T_MAX     = 102,
  parameter int BAND_DEG  = 2,
  parameter int HYST_DEG  = 1,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h60,
  localparam int NBANDS   = band_count(T_MIN, T_MAX, BAND_DEG),
  localparam int IDX_W    = $clog2(NBANDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_valid,
  input  logic [TEMP_W-1:0] conv_temp,
  input  logic              bus_busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [IDX_W-1:0]  band_idx,
  output logic              band_chg
);

  logic              apply;
  logic [TEMP_W-1:0] apply_temp;
  logic [TEMP_W-1:0] res_word;
  move_e             move;

  tsel_capture #(.TEMP_W(TEMP_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_valid (conv_valid),
    .conv_temp  (conv_temp),
    .bus_busy   (bus_busy),
    .apply      (apply),
    .apply_temp (apply_temp)
  );

  tsel_band #(
    .TEMP_W   (TEMP_W),
    .FRAC_W   (FRAC_W),
    .T_MIN    (T_MIN),
    .BAND_DEG (BAND_DEG),
    .NBANDS   (NBANDS),
    .HYST_DEG (HYST_DEG),
    .IDX_W    (IDX_W)
  ) u_band (
    .clk        (clk),
    .rst_n      (rst_n),
    .apply      (apply),
    .apply_temp (apply_temp),
    .idx        (band_idx),
    .chg        (band_chg),
    .move       (move)
  );

  tsel_result #(
    .TEMP_W    (TEMP_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .apply      (apply),
    .apply_temp (apply_temp),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .res_word   (res_word)
  );

  // R7: a busy bus freezes both the index and the result word
  assert_busy_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> ($stable(band_idx) && $stable(res_word)));

  // R10: a strobe never reaches the outputs at its own edge
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !apply) |=> $stable(res_word));

  // R9: the pulse and the index come out of reset quiet
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (!band_chg && band_idx == '0));

endmodule

// File: tb/sim_temp_band_selector.sv
module sim_temp_band_selector;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_valid = 1'b0;
  logic [15:0] conv_temp = '0;
  logic        bus_busy = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [6:0]  band_idx;
  logic        band_chg;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // model state
  int m_idx = 0;
  bit m_seen = 1'b0;
  int m_res = 0;
  int m_chg = 0;

  always #5 clk = ~clk;

  temp_band_selector u0 (
    .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_temp(conv_temp),
    .bus_busy(bus_busy), .rd_addr(rd_addr), .rd_data(rd_data),
    .band_idx(band_idx), .band_chg(band_chg)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Band computed with real arithmetic and explicit clamps
  function automatic int ref_band(input int tq);
    real d;
    int b;
    d = $floor(real'(tq) / 256.0);
    b = int'($floor((d + 40.0) / 2.0));
    if (b < 0) b = 0;
    if (b > 70) b = 70;
    return b;
  endfunction

  function automatic void model_apply(input int tq);
    int nb;
    int up;
    int dn;
    up = ref_band(tq - 256);
    dn = ref_band(tq + 256);
    if (!m_seen)        nb = ref_band(tq);
    else if (up > m_idx) nb = up;
    else if (dn < m_idx) nb = dn;
    else                 nb = m_idx;
    m_chg  = (nb != m_idx) ? 1 : 0;
    m_idx  = nb;
    m_seen = 1'b1;
    m_res  = tq & 16'hFFFF;
  endfunction

  task automatic check_outputs(input string req);
    check({req, " band_idx"}, int'(band_idx), m_idx);
    check("R8 band_chg", int'(band_chg), m_chg);
    rd_addr = 8'h60; #1;
    check("R6 rd 60h", int'(rd_data), (m_res >> 8) & 255);
    rd_addr = 8'h61; #1;
    check("R6 rd 61h", int'(rd_data), m_res & 255);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_idx = 0; m_seen = 1'b0; m_res = 0; m_chg = 0;
  endtask

  task automatic conv(input int tq, input string req);
    @(negedge clk);
    conv_valid = 1'b1;
    conv_temp  = tq[15:0];
    @(negedge clk);
    conv_valid = 1'b0;
    @(negedge clk);
    model_apply(tq);
    check_outputs(req);
  endtask

  initial begin
    int old_idx;
    do_reset();
    // R9: reset state
    @(negedge clk);
    check("R9 idx", int'(band_idx), 0);
    check("R9 chg", int'(band_chg), 0);
    rd_addr = 8'h60; #1; check("R9 rd hi", int'(rd_data), 0);
    rd_addr = 8'h61; #1; check("R9 rd lo", int'(rd_data), 0);

    // R2: first reading loads directly (55.3 deg -> band 47)
    conv(55 * 256 + 77, "R2");
    check("R2 direct", int'(band_idx), 47);

    // R10: one edge after the strobe nothing has moved yet
    @(negedge clk);
    conv_valid = 1'b1; conv_temp = 16'(-10 * 256);
    @(negedge clk);
    conv_valid = 1'b0;
    check("R10 idx early", int'(band_idx), m_idx);
    rd_addr = 8'h61; #1; check("R10 res early", int'(rd_data), m_res & 255);
    @(negedge clk);
    model_apply(-10 * 256);
    check_outputs("R10");

    // R1/R3/R4/R5: full upward then downward sweep in half-degree steps
    for (int t = -46 * 2; t <= 106 * 2; t++) conv(t * 128, "R3");
    check("R1 top clamp", int'(band_idx), 70);
    for (int t = 106 * 2; t >= -46 * 2; t--) conv(t * 128, "R4");
    check("R1 bottom clamp", int'(band_idx), 0);

    // R5: zig-zag around each band edge inside the hysteresis window
    for (int e = -38; e <= 100; e += 14) begin
      conv(e * 256 + 128, "R5");
      conv(e * 256 - 128, "R5");
      conv(e * 256 + 64, "R5");
      conv((e - 1) * 256 - 10, "R4");
      conv((e + 1) * 256, "R3");
    end

    // R6: address outside the window reads zero
    rd_addr = 8'h62; #1; check("R6 rd 62h", int'(rd_data), 0);
    rd_addr = 8'h5F; #1; check("R6 rd 5Fh", int'(rd_data), 0);

    // R7: busy bus parks and replaces
    conv(20 * 256, "R7 pre");
    old_idx = m_idx;
    @(negedge clk);
    bus_busy = 1'b1;
    conv_valid = 1'b1; conv_temp = 16'(80 * 256);
    @(negedge clk);
    conv_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 idx frozen", int'(band_idx), old_idx);
    rd_addr = 8'h60; #1; check("R7 res frozen", int'(rd_data), (m_res >> 8) & 255);
    conv_valid = 1'b1; conv_temp = 16'(-30 * 256 + 5);
    @(negedge clk);
    conv_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 still frozen", int'(band_idx), old_idx);
    bus_busy = 1'b0;
    @(negedge clk);
    model_apply(-30 * 256 + 5);
    check_outputs("R7 replaced");
    @(negedge clk);
    check("R8 single pulse", int'(band_chg), 0);

    // R2: reload after reset ignores previous state; -40.5 deg -> band 0
    do_reset();
    conv(-40 * 256 - 128, "R2 low");
    check("R2 no pulse at 0", int'(band_chg), 0);
    do_reset();
    conv(101 * 256, "R2 high");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule